// File: doc/BRIEF.md
# Synchronous Block Deframer with Block Check

This block sits behind a byte-level receiver that has already recovered character boundaries. It watches a stream of bytes, each qualified by a valid strobe, and picks out framed data blocks. A block opens with a run of synchronisation characters, followed by a start-of-text character. Payload bytes come next, and an end-of-text character closes them. One last byte carries a check value that the sender computed over the block.

The deframer forwards each payload byte with its own strobe. It never forwards the framing characters. The block keeps a running XOR over the payload bytes and the end-of-text byte, starting from zero. When the check byte arrives, the block compares it with this running value and raises either a success pulse or an error pulse. After that it goes back to hunting for synchronisation characters.

The three framing codes and the number of synchronisation characters needed before a block may open are parameters. There is no escaping inside the payload, so a payload byte equal to the end-of-text code closes the block.

Top module: `blk_deframer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid`, `blk_done` and `blk_err` are low.
- R2: A block opens only after at least MIN_SYNC (default 2) consecutive accepted bytes equal to SYNC_CODE (default 0x16), followed by STX_CODE (default 0x02). A shorter run followed by STX opens nothing, and the bytes after it are not forwarded.
- R3: Any number of extra SYNC_CODE bytes beyond MIN_SYNC, received before STX_CODE, leave the deframer waiting for STX_CODE.
- R4: Once enough SYNC bytes have been seen, any byte that is neither SYNC_CODE nor STX_CODE sends the deframer back to hunting. A later STX_CODE without a fresh SYNC run opens nothing.
- R5: Every accepted payload byte appears on `out_byte` with `out_valid` high for exactly one cycle. This happens in the cycle after the byte is accepted, and bytes keep their order. SYNC, STX, ETX and check bytes are never forwarded.
- R6: The check value is the XOR of all bytes after STX_CODE up to and including ETX_CODE (default 0x03), starting from zero. When the byte after ETX equals this value, `blk_done` pulses for one cycle, in the cycle after that byte is accepted.
- R7: When the byte after ETX differs from the check value, `blk_err` pulses for one cycle, in the cycle after that byte is accepted.
- R8: Each opened block produces exactly one of `blk_done` or `blk_err`. The two are never high together, and neither stays high for two cycles in a row.
- R9: Cycles with `in_valid` low do not advance the framing, do not change the check value, and produce no output in the following cycle.
- R10: Inside a block, payload bytes equal to SYNC_CODE or STX_CODE are forwarded as ordinary data.
- R11: After the check byte, the deframer is hunting again. A STX_CODE and payload without a new SYNC run produce no output.
- R12: A block with no payload (STX immediately followed by ETX) is accepted. Its check value equals ETX_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_byte` in this cycle |
| in_byte | input | DATA_W | Received character |
| out_valid | output | 1 | Payload byte present on `out_byte` |
| out_byte | output | DATA_W | Forwarded payload byte |
| blk_done | output | 1 | One-cycle pulse: block check matched |
| blk_err | output | 1 | One-cycle pulse: block check mismatched |

## Verification
Well-formed blocks are sent with the minimum SYNC run and with a longer one, with no payload, and with payload bytes that look like framing codes. These cases separate correct framing from a decoder that reacts to codes while inside a block. Blocks with a corrupted check byte, or sent back to back with no idle cycles, show whether the verdict pulses are told apart and cleanly spaced. Gaps in the valid strobe test that idle cycles neither shift the data nor disturb the check. Short SYNC runs, an aborted wait for STX, and a STX with no SYNC after a finished block must all stay silent, which shows that the hunt logic decides when a block opens.

// File: rtl/blkdf_pkg.sv
package blkdf_pkg;

   // Framing phases of the deframer
   typedef enum logic [1:0] {
      FR_HUNT  = 2'd0,   // counting synchronisation characters
      FR_ARMED = 2'd1,   // enough SYNC seen, waiting for start of text
      FR_BODY  = 2'd2,   // forwarding payload, accumulating check
      FR_CHECK = 2'd3    // next accepted byte is the block check
   } fr_state_e;

endpackage

// File: rtl/blkdf_sync_count.sv
module blkdf_sync_count #(
   parameter int                DATA_W    = 8,
   parameter int                MIN_SYNC  = 2,
   parameter logic [DATA_W-1:0] SYNC_CODE = DATA_W'('h16)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [DATA_W-1:0] byte_in,
   output logic              reached
);
   localparam int CW = $clog2(MIN_SYNC + 1);
   localparam logic [CW-1:0] LAST = CW'(MIN_SYNC - 1);

   logic          is_sync;
   logic [CW-1:0] cnt_q;

   assign is_sync = (byte_in == SYNC_CODE);
   assign reached = step && is_sync && (cnt_q == LAST);

   // run length of consecutive SYNC bytes; any other byte restarts it
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step)
         cnt_q <= (is_sync && !reached) ? cnt_q + 1'b1 : '0;
   end
endmodule

// File: rtl/blkdf_bcc_accum.sv
module blkdf_bcc_accum #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              upd,
   input  logic [DATA_W-1:0] byte_in,
   output logic              match
);
   logic [DATA_W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clr)
         acc_q <= '0;
      else if (upd)
         acc_q <= acc_q ^ byte_in;
   end

   assign match = (byte_in == acc_q);
endmodule

// File: rtl/blkdf_frame_ctrl.sv
module blkdf_frame_ctrl
   import blkdf_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] SYNC_CODE = DATA_W'('h16),
   parameter logic [DATA_W-1:0] STX_CODE  = DATA_W'('h02),
   parameter logic [DATA_W-1:0] ETX_CODE  = DATA_W'('h03)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   input  logic              sync_reached,
   output logic              hunt_step,
   output logic              fwd,
   output logic              acc_clr,
   output logic              acc_upd,
   output logic              finish
);
   fr_state_e state_q, state_d;

   always_comb begin
      state_d   = state_q;
      hunt_step = 1'b0;
      fwd       = 1'b0;
      acc_clr   = 1'b0;
      acc_upd   = 1'b0;
      finish    = 1'b0;
      if (in_valid) begin
         unique case (state_q)
            FR_HUNT: begin
               hunt_step = 1'b1;
               if (sync_reached) state_d = FR_ARMED;
            end
            FR_ARMED: begin
               if (in_byte == STX_CODE) begin
                  state_d = FR_BODY;
                  acc_clr = 1'b1;
               end else if (in_byte != SYNC_CODE) begin
                  state_d = FR_HUNT;
               end
            end
            FR_BODY: begin
               acc_upd = 1'b1;
               if (in_byte == ETX_CODE) state_d = FR_CHECK;
               else                     fwd     = 1'b1;
            end
            FR_CHECK: begin
               finish  = 1'b1;
               state_d = FR_HUNT;
            end
            default: state_d = FR_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= FR_HUNT;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/blk_deframer.sv
module blk_deframer
   import blkdf_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                MIN_SYNC  = 2,
   parameter logic [DATA_W-1:0] SYNC_CODE = DATA_W'('h16),
   parameter logic [DATA_W-1:0] STX_CODE  = DATA_W'('h02),
   parameter logic [DATA_W-1:0] ETX_CODE  = DATA_W'('h03)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_byte,
   output logic              blk_done,
   output logic              blk_err
);
   // elaboration-time parameter checks
   if (DATA_W < 2) begin : g_bad_width
      $error("blk_deframer: DATA_W must be at least 2");
   end
   if (MIN_SYNC < 1) begin : g_bad_sync
      $error("blk_deframer: MIN_SYNC must be at least 1");
   end
   if (SYNC_CODE == STX_CODE) begin : g_bad_codes
      $error("blk_deframer: SYNC_CODE and STX_CODE must differ");
   end

   logic hunt_step, sync_reached, fwd, acc_clr, acc_upd, finish, match;

   blkdf_sync_count #(
      .DATA_W(DATA_W), .MIN_SYNC(MIN_SYNC), .SYNC_CODE(SYNC_CODE)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .step(hunt_step),
      .byte_in(in_byte), .reached(sync_reached)
   );

   blkdf_frame_ctrl #(
      .DATA_W(DATA_W), .SYNC_CODE(SYNC_CODE),
      .STX_CODE(STX_CODE), .ETX_CODE(ETX_CODE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .sync_reached(sync_reached), .hunt_step(hunt_step), .fwd(fwd),
      .acc_clr(acc_clr), .acc_upd(acc_upd), .finish(finish)
   );

   blkdf_bcc_accum #(
      .DATA_W(DATA_W)
   ) u_bcc (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr), .upd(acc_upd),
      .byte_in(in_byte), .match(match)
   );

   // registered outputs
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_byte  <= '0;
         blk_done  <= 1'b0;
         blk_err   <= 1'b0;
      end else begin
         out_valid <= fwd;
         if (fwd) out_byte <= in_byte;
         blk_done  <= finish && match;
         blk_err   <= finish && !match;
      end
   end
endmodule

// File: rtl/blk_deframer_chk.sv
module blk_deframer_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_byte,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_byte,
   input logic              blk_done,
   input logic              blk_err
);
   // R8: never both verdicts at once
   p_single_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(blk_done && blk_err));

   // R8: a verdict lasts one cycle
   p_verdict_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_done || blk_err) |=> !(blk_done || blk_err));

   // R5: a forwarded byte is the byte accepted one cycle earlier
   p_fwd_from_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(in_valid) && out_byte == $past(in_byte)));

   // R9: an idle input cycle yields no output in the next cycle
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> !(out_valid || blk_done || blk_err));

   // R6: a verdict follows an accepted byte
   p_verdict_on_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_done || blk_err) |-> $past(in_valid));
endmodule

bind blk_deframer blk_deframer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
   .out_valid(out_valid), .out_byte(out_byte),
   .blk_done(blk_done), .blk_err(blk_err)
);

// File: tb/blk_deframer_test.sv
module blk_deframer_test;
   localparam logic [7:0] SYNC = 8'h16;
   localparam logic [7:0] STX  = 8'h02;
   localparam logic [7:0] ETX  = 8'h03;
   localparam int K_DATA = 0, K_DONE = 1, K_ERR = 2;

   typedef struct {
      int         kind;
      logic [7:0] data;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid, blk_done, blk_err;
   logic [7:0] out_byte;

   exp_t       expq[$];
   logic [7:0] pay[$];
   string      quiet_req = "R5";
   int         n_chk = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   blk_deframer uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .out_valid(out_valid), .out_byte(out_byte),
      .blk_done(blk_done), .blk_err(blk_err)
   );

   task automatic push(input int k, input logic [7:0] d, input string r);
      exp_t e;
      e.kind = k; e.data = d; e.req = r;
      expq.push_back(e);
   endtask

   task automatic take(input int k, input logic [7:0] d);
      exp_t e;
      n_chk++;
      if (expq.size() == 0) begin
         n_fail++;
         $display("FAIL %s: unexpected output kind=%0d data=%h, expected none",
                  quiet_req, k, d);
      end else begin
         e = expq.pop_front();
         if (e.kind != k || (k == K_DATA && e.data != d)) begin
            n_fail++;
            $display("FAIL %s: actual kind=%0d data=%h, expected kind=%0d data=%h",
                     e.req, k, d, e.kind, e.data);
         end
      end
   endtask

   // monitor, sampling away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (blk_done && blk_err) begin
            n_chk++; n_fail++;
            $display("FAIL R8: actual done=1 err=1, expected one verdict");
         end
         if (out_valid) take(K_DATA, out_byte);
         if (blk_done)  take(K_DONE, 8'h00);
         if (blk_err)   take(K_ERR, 8'h00);
      end
   end

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_byte  = 8'hEE;
      end
   endtask

   task automatic drained(input string r);
      n_chk++;
      if (expq.size() != 0) begin
         n_fail++;
         $display("FAIL %s: actual %0d items outstanding, expected 0", r, expq.size());
         expq.delete();
      end
   endtask

   // sends a block built from pay[] and records its expected results
   task automatic send_block(input int nsync, input bit corrupt, input int gap,
                             input string rdata, input string rend);
      logic [7:0] chk = 8'h00;
      foreach (pay[i]) begin
         push(K_DATA, pay[i], rdata);
         chk ^= pay[i];
      end
      chk ^= ETX;
      push(corrupt ? K_ERR : K_DONE, 8'h00, rend);
      for (int i = 0; i < nsync; i++) begin put(SYNC); if (gap > 0) idle(gap); end
      put(STX); if (gap > 0) idle(gap);
      foreach (pay[i]) begin put(pay[i]); if (gap > 0) idle(gap); end
      put(ETX); if (gap > 0) idle(gap);
      put(corrupt ? (chk ^ 8'h5A) : chk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R9: actual run still going, expected completion before watchdog");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: outputs quiet under reset
      n_chk++; if (out_valid || blk_done || blk_err) begin n_fail++;
         $display("FAIL R1: actual %b%b%b under reset, expected 000", out_valid, blk_done, blk_err); end
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      n_chk++; if (out_valid || blk_done || blk_err) begin n_fail++;
         $display("FAIL R1: actual %b%b%b after reset, expected 000", out_valid, blk_done, blk_err); end

      // R5/R6: good block, minimum SYNC run
      pay = '{8'h11, 8'h22, 8'hA5};
      send_block(2, 1'b0, 0, "R5", "R6"); idle(3); drained("R6");

      // R7: corrupted check byte
      pay = '{8'h7E, 8'h81};
      send_block(2, 1'b1, 0, "R5", "R7"); idle(3); drained("R7");

      // R2: one SYNC only, block must stay closed
      quiet_req = "R2";
      put(SYNC); put(STX); put(8'h44); put(8'h45); put(ETX); put(8'h47);
      idle(3); drained("R2");

      // R3: long SYNC run
      quiet_req = "R5";
      pay = '{8'h5C, 8'hF0, 8'h0F, 8'h99};
      send_block(5, 1'b0, 0, "R3", "R3"); idle(3); drained("R3");

      // R4: foreign byte while waiting for STX aborts
      quiet_req = "R4";
      put(SYNC); put(SYNC); put(8'h41); put(STX); put(8'h55); put(ETX); put(8'h56);
      idle(3); drained("R4");

      // R9: gaps in the valid strobe
      quiet_req = "R9";
      pay = '{8'hC3, 8'h3C, 8'h81};
      send_block(2, 1'b0, 2, "R9", "R9"); idle(3); drained("R9");

      // R10: payload resembling framing codes
      quiet_req = "R10";
      pay = '{SYNC, STX, SYNC, 8'h60};
      send_block(2, 1'b0, 0, "R10", "R10"); idle(3); drained("R10");

      // R12: empty payload
      quiet_req = "R12";
      pay.delete();
      send_block(2, 1'b0, 0, "R12", "R12"); idle(3); drained("R12");

      // R11: no SYNC after a finished block
      quiet_req = "R11";
      put(STX); put(8'h9A); put(ETX); put(8'h99);
      idle(3); drained("R11");

      // R8: back-to-back blocks, good then bad, no idle between them
      quiet_req = "R8";
      pay = '{8'h12, 8'h34};
      send_block(2, 1'b0, 0, "R8", "R8");
      pay = '{8'hAB};
      send_block(3, 1'b1, 0, "R8", "R8");
      idle(4); drained("R8");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule